// File: doc/BRIEF.md
# Path Remote Defect Code Generator

This block produces the 3-bit path remote defect code that the transmit side places in the low bits (3:1) of the path status byte of each outgoing STS-1 frame. It serves up to three STS-1 channels. Each channel receives its own path defect flags from the local receive side: alarm indication, loss of pointer, payload label mismatch, unequipped and trace identifier mismatch. From these flags the block builds the code under one of two encodings. The legacy one-bit encoding reports only server-layer trouble. The enhanced encoding tells server, connectivity and payload defects apart.

A code that the hardware raises is never allowed to flicker. Once a defect has raised it, the code stays up for a minimum number of frame strobes after the defect was last seen. Software can take over each channel with a fixed code. A protection-side code can also be selected in place of the locally generated one. When the line runs as a single STM-1 container, only the first channel position carries a code. When it runs as three STS-1 tributaries (STS-3), every channel is independent.

Top module: `path_rdi_gen`

## Requirements
- R1: After reset, with no defect present, every active channel outputs 3'b000 when enh_mode=0 and 3'b001 when enh_mode=1.
- R2: With sw_sel=1, channel n outputs sw_code[3n+2:3n] unchanged, whatever the defects, the mode and prot_sel are.
- R3: With enh_mode=0, the hardware code is 3'b100 when unmasked AIS or LOP is present and 3'b000 otherwise. PLM, UNEQ and TIM have no effect.
- R4: With enh_mode=1, the hardware code is 3'b101 for a server defect (AIS or LOP), 3'b110 for a connectivity defect (UNEQ or TIM), 3'b010 for a payload defect (PLM) and 3'b001 when no defect is present. It is never 3'b000.
- R5: When defects of several classes are present at once, server wins over connectivity, and connectivity wins over payload.
- R6: A hardware code that a defect raised stays unchanged until HOLD_FRAMES (default 20) frame strobes have been seen after the last clock in which the defect was present. It falls back on the HOLD_FRAMES-th strobe. Cycles without a strobe do not shorten the hold.
- R7: A defect of higher rank that arrives during a hold replaces the code on the next clock and restarts the hold. A lower-rank defect does not replace the held code. It takes over on the strobe that ends the hold.
- R8: Inhibit bits remove a defect's contribution: bit 0 AIS, bit 1 LOP, bit 2 PLM, bit 3 UNEQ, bit 4 TIM. A set bit makes the block behave as if that flag were 0.
- R9: With sw_sel=0 and prot_sel=1, channel n outputs prot_code[3n+2:3n] in place of its local hardware code.
- R10: With stm1_mode=1, channels 1 and 2 output 3'b000 under any input. Channel 0 works normally, using its own register and defect flags.
- R11: With stm1_mode=0, each channel's code depends only on that channel's defect flags, software field and protection field.
- R12: A defect flag registers on the clock edge that samples it, so the code reflects it from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse per frame; drives the hold count |
| sw_sel | input | 1 | 1: software codes drive all channels |
| prot_sel | input | 1 | 1: protection-side codes replace local hardware codes |
| enh_mode | input | 1 | 0: legacy encoding, 1: enhanced encoding |
| stm1_mode | input | 1 | 1: single container, only channel 0 carries a code |
| inhibit | input | 5 | Per-defect mask (AIS, LOP, PLM, UNEQ, TIM from bit 0) |
| ais | input | NUM_CH | Per-channel alarm indication defect |
| lop | input | NUM_CH | Per-channel loss of pointer defect |
| plm | input | NUM_CH | Per-channel payload label mismatch defect |
| uneq | input | NUM_CH | Per-channel unequipped defect |
| tim | input | NUM_CH | Per-channel trace identifier mismatch defect |
| sw_code | input | 3*NUM_CH | Software code, 3 bits per channel |
| prot_code | input | 3*NUM_CH | Protection-side code, 3 bits per channel |
| rdi_code | output | 3*NUM_CH | Outgoing code, 3 bits per channel |

## Verification
Both encodings are swept over all 32 defect combinations against all 32 inhibit masks. Each of the three channels gets a different combination in the same run, so a mix-up in the priority order, a mask bit mapped to the wrong flag, or crosstalk between channels produces a visibly wrong code. The hold is tested with strobes separated by idle cycles, which separates counting by frame from counting by clock. It is also tested with an escalation part-way through a hold, and with a lower-rank defect that waits for the hold to end, which show whether the count restarts and whether a lower code takes over when it should. Sweeps of the software and protection fields, both in the three-channel layout and the single-container layout, check the source selection order and that the unused positions are forced to zero.

// File: rtl/path_rdi_pkg.sv
package path_rdi_pkg;

   localparam int unsigned CODE_W  = 3;
   localparam int unsigned DEF_NUM = 5;
   localparam int unsigned DEF_AIS  = 0;
   localparam int unsigned DEF_LOP  = 1;
   localparam int unsigned DEF_PLM  = 2;
   localparam int unsigned DEF_UNEQ = 3;
   localparam int unsigned DEF_TIM  = 4;

   typedef enum logic [1:0] {
      RANK_NONE    = 2'd0,
      RANK_PAYLOAD = 2'd1,
      RANK_CONN    = 2'd2,
      RANK_SERVER  = 2'd3
   } rdi_rank_e;

   function automatic logic [CODE_W-1:0] rank_to_code(rdi_rank_e r, logic enh);
      logic [CODE_W-1:0] c;
      if (!enh) begin
         c = (r != RANK_NONE) ? 3'b100 : 3'b000;
      end else begin
         case (r)
            RANK_SERVER:  c = 3'b101;
            RANK_CONN:    c = 3'b110;
            RANK_PAYLOAD: c = 3'b010;
            default:      c = 3'b001;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/rdi_defect_rank.sv
module rdi_defect_rank
   import path_rdi_pkg::*;
(
   input  logic               ais,
   input  logic               lop,
   input  logic               plm,
   input  logic               uneq,
   input  logic               tim,
   input  logic [DEF_NUM-1:0] inhibit,
   input  logic               enh_mode,
   output rdi_rank_e          rank
);

   logic srv_hit, conn_hit, pay_hit;

   always_comb begin
      srv_hit  = (ais & ~inhibit[DEF_AIS]) | (lop & ~inhibit[DEF_LOP]);
      conn_hit = enh_mode & ((uneq & ~inhibit[DEF_UNEQ]) | (tim & ~inhibit[DEF_TIM]));
      pay_hit  = enh_mode & plm & ~inhibit[DEF_PLM];
      if (srv_hit)       rank = RANK_SERVER;
      else if (conn_hit) rank = RANK_CONN;
      else if (pay_hit)  rank = RANK_PAYLOAD;
      else               rank = RANK_NONE;
   end

endmodule

// File: rtl/rdi_hold_timer.sv
module rdi_hold_timer
   import path_rdi_pkg::*;
#(
   parameter int unsigned HOLD_FRAMES = 20
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_stb,
   input  rdi_rank_e cur_rank,
   output rdi_rank_e hw_rank
);

   localparam int unsigned CNT_W = $clog2(HOLD_FRAMES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_FRAMES);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   rdi_rank_e        rank_q;
   logic             expire, load;

   always_comb begin
      expire = (cnt_q == '0) | (frame_stb & (cnt_q == CNT_ONE));
      load   = (cur_rank != RANK_NONE) & ((cur_rank >= rank_q) | expire);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rank_q <= RANK_NONE;
      end else if (load) begin
         cnt_q  <= CNT_LOAD;
         rank_q <= cur_rank;
      end else if (frame_stb && cnt_q != '0) begin
         cnt_q  <= cnt_q - CNT_ONE;
      end
   end

   assign hw_rank = (cnt_q != '0) ? rank_q : RANK_NONE;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LOAD);                                              // R6
   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !frame_stb) |=> (hw_rank != RANK_NONE));         // R6
   AST_DEFECT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_rank != RANK_NONE) |=> (hw_rank != RANK_NONE));             // R12
   AST_SERVER_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_rank == RANK_SERVER && !(frame_stb && cnt_q == CNT_ONE))
      |=> (hw_rank == RANK_SERVER));                                   // R7

endmodule

// File: rtl/rdi_code_mux.sv
module rdi_code_mux
   import path_rdi_pkg::*;
(
   input  logic              chan_en,
   input  logic              sw_sel,
   input  logic              prot_sel,
   input  logic              enh_mode,
   input  rdi_rank_e         hw_rank,
   input  logic [CODE_W-1:0] sw_val,
   input  logic [CODE_W-1:0] prot_val,
   output logic [CODE_W-1:0] code_out
);

   always_comb begin
      if (!chan_en)      code_out = '0;
      else if (sw_sel)   code_out = sw_val;
      else if (prot_sel) code_out = prot_val;
      else               code_out = rank_to_code(hw_rank, enh_mode);
   end

endmodule

// File: rtl/path_rdi_gen.sv
module path_rdi_gen
   import path_rdi_pkg::*;
#(
   parameter int unsigned NUM_CH      = 3,
   parameter int unsigned HOLD_FRAMES = 20
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     frame_stb,
   input  logic                     sw_sel,
   input  logic                     prot_sel,
   input  logic                     enh_mode,
   input  logic                     stm1_mode,
   input  logic [4:0]               inhibit,
   input  logic [NUM_CH-1:0]        ais,
   input  logic [NUM_CH-1:0]        lop,
   input  logic [NUM_CH-1:0]        plm,
   input  logic [NUM_CH-1:0]        uneq,
   input  logic [NUM_CH-1:0]        tim,
   input  logic [3*NUM_CH-1:0]      sw_code,
   input  logic [3*NUM_CH-1:0]      prot_code,
   output logic [3*NUM_CH-1:0]      rdi_code
);

   localparam int unsigned BUS_W = CODE_W * NUM_CH;

   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("path_rdi_gen: NUM_CH must lie in 1..3");
   end
   if (HOLD_FRAMES < 2) begin : g_bad_hold
      $error("path_rdi_gen: HOLD_FRAMES must be at least 2");
   end
   if (BUS_W != $bits(rdi_code)) begin : g_bad_bus
      $error("path_rdi_gen: code bus width mismatch");
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      rdi_rank_e   cur_rank, hw_rank;
      logic        chan_en;
      logic [CODE_W-1:0] code_w;

      if (ch == 0) begin : g_lead
         assign chan_en = 1'b1;
      end else begin : g_trib
         assign chan_en = ~stm1_mode;
         AST_STM1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            stm1_mode |-> (rdi_code[ch*CODE_W +: CODE_W] == '0));      // R10
      end

      rdi_defect_rank u_rank (
         .ais      (ais[ch]),
         .lop      (lop[ch]),
         .plm      (plm[ch]),
         .uneq     (uneq[ch]),
         .tim      (tim[ch]),
         .inhibit  (inhibit),
         .enh_mode (enh_mode),
         .rank     (cur_rank)
      );

      rdi_hold_timer #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
         .clk       (clk),
         .rst_n     (rst_n),
         .frame_stb (frame_stb),
         .cur_rank  (cur_rank),
         .hw_rank   (hw_rank)
      );

      rdi_code_mux u_mux (
         .chan_en  (chan_en),
         .sw_sel   (sw_sel),
         .prot_sel (prot_sel),
         .enh_mode (enh_mode),
         .hw_rank  (hw_rank),
         .sw_val   (sw_code[ch*CODE_W +: CODE_W]),
         .prot_val (prot_code[ch*CODE_W +: CODE_W]),
         .code_out (code_w)
      );

      assign rdi_code[ch*CODE_W +: CODE_W] = code_w;

      AST_LEGACY_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (!enh_mode && !sw_sel && !prot_sel)
         |-> (code_w == 3'b000 || code_w == 3'b100));                  // R3
      AST_ENH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (enh_mode && !sw_sel && !prot_sel && chan_en)
         |-> (code_w != 3'b000));                                      // R4
   end

endmodule

// File: tb/path_rdi_gen_tb_top.sv
module path_rdi_gen_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NCH  = 3;
   localparam int HOLD = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_stb = 1'b0;
   logic sw_sel = 1'b0, prot_sel = 1'b0, enh_mode = 1'b0, stm1_mode = 1'b0;
   logic [4:0] inhibit = '0;
   logic [NCH-1:0] ais = '0, lop = '0, plm = '0, uneq = '0, tim = '0;
   logic [3*NCH-1:0] sw_code = '0, prot_code = '0;
   logic [3*NCH-1:0] rdi_code;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   path_rdi_gen #(.NUM_CH(NCH), .HOLD_FRAMES(HOLD)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sw_sel(sw_sel),
      .prot_sel(prot_sel), .enh_mode(enh_mode), .stm1_mode(stm1_mode),
      .inhibit(inhibit), .ais(ais), .lop(lop), .plm(plm), .uneq(uneq),
      .tim(tim), .sw_code(sw_code), .prot_code(prot_code), .rdi_code(rdi_code)
   );

   function automatic logic [2:0] exp_code(logic [4:0] d, logic [4:0] m, logic enh);
      logic [4:0] e;
      e = d & ~m;
      if (!enh) return (e[0] | e[1]) ? 3'b100 : 3'b000;
      if (e[0] | e[1]) return 3'b101;
      if (e[3] | e[4]) return 3'b110;
      if (e[2]) return 3'b010;
      return 3'b001;
   endfunction

   function automatic logic [2:0] chan(int c);
      return rdi_code[c*3 +: 3];
   endfunction

   task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic set_defects(input int c, input logic [4:0] d);
      ais[c] = d[0]; lop[c] = d[1]; plm[c] = d[2]; uneq[c] = d[3]; tim[c] = d[4];
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic strobe();
      @(negedge clk); frame_stb = 1'b1;
      @(negedge clk); frame_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      // R1: reset state in both encodings
      for (int e = 0; e < 2; e++) begin
         enh_mode = e[0];
         do_reset();
         for (int c = 0; c < NCH; c++) check("R1 reset code", chan(c), e[0] ? 3'b001 : 3'b000);
      end

      // R3 R4 R5 R8 R11 R12: sweep defects x masks x encodings, channels differ
      for (int e = 0; e < 2; e++) begin
         for (int m = 0; m < 32; m++) begin
            for (int d = 0; d < 32; d++) begin
               @(negedge clk);
               rst_n = 1'b0; enh_mode = e[0]; inhibit = m[4:0];
               set_defects(0, d[4:0]);
               set_defects(1, 5'((d + 7) % 32));
               set_defects(2, 5'((d + 13) % 32));
               @(negedge clk); rst_n = 1'b1;
               @(negedge clk);
               check(e[0] ? "R4 R5 R8 enhanced ch0" : "R3 R8 legacy ch0",
                     chan(0), exp_code(d[4:0], m[4:0], e[0]));
               check("R11 ch1 independent", chan(1), exp_code(5'((d + 7) % 32), m[4:0], e[0]));
               check("R11 ch2 independent", chan(2), exp_code(5'((d + 13) % 32), m[4:0], e[0]));
            end
         end
      end
      for (int c = 0; c < NCH; c++) set_defects(c, 5'd0);
      inhibit = '0;

      // R6: hold counts strobes, not clocks
      enh_mode = 1'b1;
      do_reset();
      @(negedge clk); ais[0] = 1'b1;
      @(negedge clk); ais[0] = 1'b0;
      check("R12 raised next clock", chan(0), 3'b101);
      for (int k = 1; k <= HOLD; k++) begin
         strobe();
         @(negedge clk);
         check("R6 hold window", chan(0), (k < HOLD) ? 3'b101 : 3'b001);
      end

      // R7: escalation restarts the hold
      do_reset();
      @(negedge clk); plm[0] = 1'b1;
      @(negedge clk); plm[0] = 1'b0;
      check("R7 payload raised", chan(0), 3'b010);
      for (int k = 0; k < 3; k++) strobe();
      @(negedge clk); uneq[0] = 1'b1;
      @(negedge clk); uneq[0] = 1'b0;
      check("R7 escalated", chan(0), 3'b110);
      for (int k = 1; k <= HOLD; k++) begin
         strobe();
         if (k >= HOLD - 1) check("R7 restarted hold", chan(0), (k < HOLD) ? 3'b110 : 3'b001);
      end

      // R7: lower rank waits for hold end, then takes over
      do_reset();
      @(negedge clk); lop[0] = 1'b1;
      @(negedge clk); lop[0] = 1'b0; plm[0] = 1'b1;
      @(negedge clk);
      check("R7 lower ignored", chan(0), 3'b101);
      for (int k = 1; k <= HOLD; k++) begin
         strobe();
         if (k >= HOLD - 1) check("R7 lower takeover", chan(0), (k < HOLD) ? 3'b101 : 3'b010);
      end
      plm[0] = 1'b0;
      for (int k = 0; k < HOLD; k++) strobe();
      check("R6 final clear", chan(0), 3'b001);

      // R2 R9: source selection over code fields
      ais = '1;
      for (int v = 0; v < 8; v++) begin
         sw_code   = {3'((v + 5) % 8), 3'((v + 3) % 8), 3'(v)};
         prot_code = {3'((v + 1) % 8), 3'((v + 6) % 8), 3'((v + 2) % 8)};
         sw_sel = 1'b1; prot_sel = 1'b1;
         @(negedge clk);
         for (int c = 0; c < NCH; c++) check("R2 software field", chan(c), sw_code[c*3 +: 3]);
         sw_sel = 1'b0;
         @(negedge clk);
         for (int c = 0; c < NCH; c++) check("R9 protection field", chan(c), prot_code[c*3 +: 3]);
         prot_sel = 1'b0;
      end

      // R10: single container mode
      stm1_mode = 1'b1;
      sw_code = 9'o765;
      sw_sel = 1'b1;
      @(negedge clk);
      check("R10 ch0 software", chan(0), 3'o5);
      check("R10 ch1 quiet", chan(1), 3'b000);
      check("R10 ch2 quiet", chan(2), 3'b000);
      sw_sel = 1'b0;
      do_reset();
      check("R10 ch0 hardware", chan(0), 3'b101);
      check("R10 ch1 quiet hw", chan(1), 3'b000);
      check("R10 ch2 quiet hw", chan(2), 3'b000);

      done = 1'b1;
      report();
   end

endmodule